// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through

This block stores words written on one clock and returns them on a second, unrelated clock. The write and read clocks may run at any frequencies and have no fixed ratio. Storage depth is a power of two, 2^AW, with 256 words by default. The data width is 18 bits by default. Each pointer crosses to the other clock domain as Gray code through two flip-flops. The empty condition is computed in the read domain and the full condition in the write domain. Both are therefore conservative: a flag may stay asserted a few cycles after the other side has moved, and it never clears early.

The read timing mode is latched while the master reset is held low. In standard mode a word reaches the output register only when the reader asks for it. In fall-through mode the head word loads into the output register by itself. Later words advance only when a read is requested. In fall-through mode the two status outputs change meaning to "output holds a word" and "input has room". The output of one unit can then feed the input of the next, so several units chain for depth with no glue logic. An output enable gates the read data to zero when the data is not wanted.

The read side is a two-state machine. OUT_DRY means the output register holds no word that can be consumed. OUT_WET means it holds one. The reset state is OUT_DRY. The transition DRY_TO_WET happens on any pop from storage. The transition WET_TO_DRY happens only in fall-through mode, on a read edge when storage is empty. In standard mode OUT_WET is kept after the first read, and the register holds the last word read.

Top module: `dcfifo_top`

## Requirements
- R1: While wr_en_n is low and the FIFO is not full, each rising wclk edge stores wdata. Words come out in the order they were written, with no loss and no duplicates.
- R2: In standard mode, while rd_en_n is low and storage holds a word, a rising rclk edge loads the oldest word into the output register. rdata shows that word after the same edge.
- R3: In standard mode, a written word stays off rdata until a read is performed. rd_flag_n is low while storage is empty and high while it holds at least one word.
- R4: In fall-through mode, the first word written into an empty FIFO appears on rdata with no read request. At that point rd_flag_n goes low, on the third rising rclk edge after the write edge. rd_flag_n is still high after the second such edge.
- R5: In fall-through mode, words after the first advance only on rclk edges with rd_en_n low. A read edge that finds storage empty sets rd_flag_n high.
- R6: mode_sel is sampled on clock edges while mrst_n is low (1 selects fall-through, 0 selects standard). Later changes of mode_sel have no effect until the next master reset.
- R7: In standard mode, wr_flag_n is low when full. In fall-through mode, wr_flag_n is low while there is room. Capacity is 2^AW words in standard mode and 2^AW+1 in fall-through mode, counting the output register.
- R8: half_full is high while the write-domain stored count exceeds 2^AW/2, where the stored count excludes the fall-through output register.
- R9: almost_empty is high while the read-domain stored count is at most OFFSET. almost_full is high while the write-domain stored count is at least 2^AW-OFFSET. The default OFFSET is 127.
- R10: A write while full and a read while empty are ignored. They move no pointer, and rdata keeps its previous word.
- R11: While oe_n is high, rdata is zero. While oe_n is low, rdata shows the output register.
- R12: mrst_n low asynchronously clears both pointers, the synchronisers and the output register. Until reset is released, rdata is zero, half_full and almost_full are low, almost_empty is high, and storage is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low, asynchronous assertion |
| mode_sel | input | 1 | Timing mode sampled during reset: 1 selects fall-through, 0 selects standard |
| wr_en_n | input | 1 | Write request, active low |
| wdata | input | DW | Write data |
| rd_en_n | input | 1 | Read request, active low |
| oe_n | input | 1 | Output enable, active low; gates rdata to zero when high |
| rdata | output | DW | Read data from the output register |
| wr_flag_n | output | 1 | Full in standard mode; input-ready in fall-through mode; active low |
| rd_flag_n | output | 1 | Empty in standard mode; output-ready in fall-through mode; active low |
| half_full | output | 1 | Stored count above half depth (write domain) |
| almost_empty | output | 1 | Stored count at most OFFSET (read domain) |
| almost_full | output | 1 | Stored count at least depth minus OFFSET (write domain) |

## Verification
The bench drives the count through 127, 128 and 129 words. Those are the points where almost_empty, half_full and almost_full each change state. An off-by-one threshold shows up as a flag one word early or late. It fills the FIFO and then writes one more word. A design that lets that write through, or that moves a pointer on a read from empty storage, returns a stray or repeated word in the drained sequence.

In fall-through mode the bench counts read-clock edges after a single write. It checks that the word appears on exactly the third edge. It then fills the FIFO with writes gated by the ready flag and expects exactly one more word than the storage depth. A design that forgot the output register, or one with inverted flag meanings, gives the wrong count or stalls.

The bench also flips mode_sel after reset to catch a mode that is not latched. It asserts reset with words in flight to catch state that is cleared only on a clock edge.

// File: rtl/dcfifo_pkg.sv
`timescale 1ns/1ps
package dcfifo_pkg;
    typedef enum logic {
        OUT_DRY = 1'b0,
        OUT_WET = 1'b1
    } out_state_t;
endpackage

// File: rtl/dcfifo_sync.sv
`timescale 1ns/1ps
module dcfifo_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dcfifo_wctl.sv
`timescale 1ns/1ps
module dcfifo_wctl #(
    parameter int AW     = 8,
    parameter int OFFSET = 127
) (
    input  logic          wclk,
    input  logic          mrst_n,
    input  logic          mode_sel,
    input  logic          wr_en_n,
    input  logic [AW:0]   r_gray_s,
    output logic [AW-1:0] w_addr,
    output logic          w_fire,
    output logic [AW:0]   w_gray,
    output logic [AW:0]   w_bin,
    output logic          w_full,
    output logic          wr_flag_n,
    output logic          half_full,
    output logic          almost_full
);
    localparam int          DEPTH  = 1 << AW;
    localparam logic [AW:0] HALF_V = (AW+1)'(DEPTH / 2);
    localparam logic [AW:0] AF_V   = (AW+1)'(DEPTH - OFFSET);

    logic          mode_w;
    logic [AW:0]   rs_bin;
    logic [AW:0]   count_w;
    logic [AW:0]   w_nx;

    for (genvar i = 0; i <= AW; i++) begin : g_g2b
        assign rs_bin[i] = ^r_gray_s[AW:i];
    end

    always_ff @(posedge wclk) begin
        if (!mrst_n) mode_w <= mode_sel;
    end

    always_comb begin
        w_full  = (w_gray == {~r_gray_s[AW:AW-1], r_gray_s[AW-2:0]});
        w_fire  = !wr_en_n && !w_full;
        w_nx    = w_bin + (AW+1)'(1);
        count_w = w_bin - rs_bin;
        w_addr  = w_bin[AW-1:0];
    end

    always_ff @(posedge wclk or negedge mrst_n) begin
        if (!mrst_n) begin
            w_bin  <= '0;
            w_gray <= '0;
        end else if (w_fire) begin
            w_bin  <= w_nx;
            w_gray <= w_nx ^ (w_nx >> 1);
        end
    end

    always_comb begin
        wr_flag_n   = mode_w ? w_full : !w_full;
        half_full   = count_w > HALF_V;
        almost_full = count_w >= AF_V;
    end
endmodule

// File: rtl/dcfifo_rctl.sv
`timescale 1ns/1ps
module dcfifo_rctl
    import dcfifo_pkg::*;
#(
    parameter int AW     = 8,
    parameter int DW     = 18,
    parameter int OFFSET = 127
) (
    input  logic          rclk,
    input  logic          mrst_n,
    input  logic          mode_sel,
    input  logic          rd_en_n,
    input  logic [AW:0]   w_gray_s,
    input  logic [DW-1:0] mem_q,
    output logic [AW-1:0] r_addr,
    output logic [AW:0]   r_gray,
    output logic [AW:0]   r_bin,
    output logic [DW-1:0] out_q,
    output logic          r_empty,
    output logic          mode_r,
    output out_state_t    state,
    output logic          rd_flag_n,
    output logic          almost_empty
);
    localparam logic [AW:0] AE_V = (AW+1)'(OFFSET);

    out_state_t  state_nx;
    logic        pop;
    logic [AW:0] ws_bin;
    logic [AW:0] count_r;
    logic [AW:0] r_nx;

    for (genvar i = 0; i <= AW; i++) begin : g_g2b
        assign ws_bin[i] = ^w_gray_s[AW:i];
    end

    always_ff @(posedge rclk) begin
        if (!mrst_n) mode_r <= mode_sel;
    end

    always_comb begin
        r_empty = (r_gray == w_gray_s);
        if (mode_r) pop = !r_empty && ((state == OUT_DRY) || !rd_en_n);
        else        pop = !r_empty && !rd_en_n;
        r_nx    = r_bin + (AW+1)'(1);
        count_r = ws_bin - r_bin;
        r_addr  = r_bin[AW-1:0];
    end

    // State register
    always_ff @(posedge rclk or negedge mrst_n) begin
        if (!mrst_n) state <= OUT_DRY;
        else         state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            OUT_DRY: if (pop) state_nx = OUT_WET;
            OUT_WET: if (mode_r && !rd_en_n && !pop) state_nx = OUT_DRY;
        endcase
    end

    always_ff @(posedge rclk or negedge mrst_n) begin
        if (!mrst_n) begin
            r_bin  <= '0;
            r_gray <= '0;
            out_q  <= '0;
        end else if (pop) begin
            r_bin  <= r_nx;
            r_gray <= r_nx ^ (r_nx >> 1);
            out_q  <= mem_q;
        end
    end

    // Output process
    always_comb begin
        rd_flag_n    = mode_r ? (state == OUT_DRY) : !r_empty;
        almost_empty = count_r <= AE_V;
    end
endmodule

// File: rtl/dcfifo_top.sv
`timescale 1ns/1ps
module dcfifo_top
    import dcfifo_pkg::*;
#(
    parameter int DW     = 18,
    parameter int AW     = 8,
    parameter int OFFSET = 127
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          mrst_n,
    input  logic          mode_sel,
    input  logic          wr_en_n,
    input  logic [DW-1:0] wdata,
    input  logic          rd_en_n,
    input  logic          oe_n,
    output logic [DW-1:0] rdata,
    output logic          wr_flag_n,
    output logic          rd_flag_n,
    output logic          half_full,
    output logic          almost_empty,
    output logic          almost_full
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] w_addr, r_addr;
    logic          w_fire, w_full, r_empty, mode_r;
    logic [AW:0]   w_gray, w_bin, r_gray, r_bin, w_gray_s, r_gray_s;
    logic [DW-1:0] out_q;
    out_state_t    state;

    always_ff @(posedge wclk) begin
        if (w_fire) mem[w_addr] <= wdata;
    end

    dcfifo_sync #(.W(AW+1)) u_sync_w2r (
        .clk(rclk), .rst_n(mrst_n), .d(w_gray), .q(w_gray_s)
    );

    dcfifo_sync #(.W(AW+1)) u_sync_r2w (
        .clk(wclk), .rst_n(mrst_n), .d(r_gray), .q(r_gray_s)
    );

    dcfifo_wctl #(.AW(AW), .OFFSET(OFFSET)) u_wctl (
        .wclk(wclk), .mrst_n(mrst_n), .mode_sel(mode_sel), .wr_en_n(wr_en_n),
        .r_gray_s(r_gray_s), .w_addr(w_addr), .w_fire(w_fire),
        .w_gray(w_gray), .w_bin(w_bin), .w_full(w_full),
        .wr_flag_n(wr_flag_n), .half_full(half_full), .almost_full(almost_full)
    );

    dcfifo_rctl #(.AW(AW), .DW(DW), .OFFSET(OFFSET)) u_rctl (
        .rclk(rclk), .mrst_n(mrst_n), .mode_sel(mode_sel), .rd_en_n(rd_en_n),
        .w_gray_s(w_gray_s), .mem_q(mem[r_addr]), .r_addr(r_addr),
        .r_gray(r_gray), .r_bin(r_bin), .out_q(out_q), .r_empty(r_empty),
        .mode_r(mode_r), .state(state), .rd_flag_n(rd_flag_n),
        .almost_empty(almost_empty)
    );

    assign rdata = oe_n ? '0 : out_q;
endmodule

// File: rtl/dcfifo_chk.sv
`timescale 1ns/1ps
module dcfifo_chk #(
    parameter int AW = 8
) (
    input logic        wclk,
    input logic        rclk,
    input logic        mrst_n,
    input logic        wr_en_n,
    input logic        w_full,
    input logic        r_empty,
    input logic        mode_r,
    input logic        rd_flag_n,
    input logic        half_full,
    input logic        almost_full,
    input logic        almost_empty,
    input logic [AW:0] w_bin,
    input logic [AW:0] w_gray,
    input logic [AW:0] r_bin
);
    AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!mrst_n)
        (w_full && !wr_en_n) |=> $stable(w_bin)); // R10
    AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!mrst_n)
        r_empty |=> $stable(r_bin)); // R10
    AST_GRAY_STEP: assert property (@(posedge wclk) disable iff (!mrst_n)
        $onehot0(w_gray ^ $past(w_gray))); // R1
    AST_FULL_FLAGS: assert property (@(posedge wclk) disable iff (!mrst_n)
        w_full |-> (half_full && almost_full)); // R8
    AST_EMPTY_AE: assert property (@(posedge rclk) disable iff (!mrst_n)
        r_empty |-> almost_empty); // R9
    AST_MODE_HOLD: assert property (@(posedge rclk) disable iff (!mrst_n)
        $past(mrst_n) |-> $stable(mode_r)); // R6
    AST_FT_LOAD: assert property (@(posedge rclk) disable iff (!mrst_n)
        (mode_r && $fell(rd_flag_n)) |-> $past(!r_empty)); // R4
endmodule

bind dcfifo_top dcfifo_chk #(.AW(AW)) u_chk (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .wr_en_n(wr_en_n),
    .w_full(w_full), .r_empty(r_empty), .mode_r(mode_r),
    .rd_flag_n(rd_flag_n), .half_full(half_full), .almost_full(almost_full),
    .almost_empty(almost_empty), .w_bin(w_bin), .w_gray(w_gray), .r_bin(r_bin)
);

// File: tb/tb_dcfifo_top.sv
`timescale 1ns/1ps
module tb_dcfifo_top;
    localparam int DW = 18;
    localparam int AW = 8;
    localparam int DEPTH = 1 << AW;

    logic wclk = 1'b0, rclk = 1'b0;
    logic mrst_n = 1'b0, mode_sel = 1'b0;
    logic wr_en_n = 1'b1, rd_en_n = 1'b1, oe_n = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic wr_flag_n, rd_flag_n, half_full, almost_empty, almost_full;

    int n_cmp = 0, n_bad = 0;
    bit finished = 1'b0;

    // {oe_n, written word, expected rdata}
    localparam logic [2*DW:0] VEC [8] = '{
        {1'b0, 18'h00001, 18'h00001},
        {1'b0, 18'h3FFFF, 18'h3FFFF},
        {1'b1, 18'h2AAAA, 18'h00000},
        {1'b0, 18'h15555, 18'h15555},
        {1'b0, 18'h00000, 18'h00000},
        {1'b1, 18'h12345, 18'h00000},
        {1'b0, 18'h20001, 18'h20001},
        {1'b0, 18'h0F0F0, 18'h0F0F0}
    };

    dcfifo_top #(.DW(DW), .AW(AW), .OFFSET(127)) dut (
        .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .mode_sel(mode_sel),
        .wr_en_n(wr_en_n), .wdata(wdata), .rd_en_n(rd_en_n), .oe_n(oe_n),
        .rdata(rdata), .wr_flag_n(wr_flag_n), .rd_flag_n(rd_flag_n),
        .half_full(half_full), .almost_empty(almost_empty), .almost_full(almost_full)
    );

    always #2 wclk = ~wclk;
    initial begin
        #3;
        forever begin
            rclk = 1'b1; #7;
            rclk = 1'b0; #7;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic do_reset(input logic m);
        mrst_n = 1'b0;
        mode_sel = m;
        wr_en_n = 1'b1;
        rd_en_n = 1'b1;
        repeat (3) @(negedge rclk);
        repeat (3) @(negedge wclk);
        mrst_n = 1'b1;
        mode_sel = ~m;
        repeat (2) @(negedge wclk);
    endtask

    task automatic wr_one(input logic [DW-1:0] d);
        @(negedge wclk);
        wdata = d;
        wr_en_n = 1'b0;
        @(negedge wclk);
        wr_en_n = 1'b1;
    endtask

    task automatic wr_burst(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            @(negedge wclk);
            wdata = DW'(base + i);
            wr_en_n = 1'b0;
        end
        @(negedge wclk);
        wr_en_n = 1'b1;
    endtask

    task automatic rd_one();
        @(negedge rclk);
        rd_en_n = 1'b0;
        @(negedge rclk);
        rd_en_n = 1'b1;
    endtask

    task automatic settle();
        repeat (4) @(negedge rclk);
        repeat (4) @(negedge wclk);
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int acc;
        // ---------------- standard mode ----------------
        do_reset(1'b0);
        chk("R12 reset rd_flag_n", 32'(rd_flag_n), 0);
        chk("R12 reset wr_flag_n", 32'(wr_flag_n), 1);
        chk("R12 reset half_full", 32'(half_full), 0);
        chk("R12 reset almost_empty", 32'(almost_empty), 1);
        chk("R12 reset almost_full", 32'(almost_full), 0);
        chk("R12 reset rdata", 32'(rdata), 0);

        wr_one(18'h2A5A5);
        settle();
        chk("R3 word held off output", 32'(rdata), 0);
        chk("R3 not empty", 32'(rd_flag_n), 1);
        rd_one();
        chk("R2 read word", 32'(rdata), 32'h2A5A5);
        chk("R3 empty after read", 32'(rd_flag_n), 0);
        oe_n = 1'b1; #1;
        chk("R11 oe_n high gates", 32'(rdata), 0);
        oe_n = 1'b0; #1;
        chk("R11 oe_n low drives", 32'(rdata), 32'h2A5A5);

        // table walk: writes in order, reads in order with output enable column (R1 R11)
        for (int i = 0; i < 8; i++) wr_one(VEC[i][2*DW-1:DW]);
        settle();
        for (int i = 0; i < 8; i++) begin
            rd_one();
            oe_n = VEC[i][2*DW];
            #1;
            chk("R1 table order", 32'(rdata), 32'(VEC[i][DW-1:0]));
            oe_n = 1'b0;
        end

        // thresholds and full (R8 R9 R7)
        wr_burst(127, 0);
        settle();
        chk("R9 almost_empty at 127", 32'(almost_empty), 1);
        chk("R8 half_full at 127", 32'(half_full), 0);
        wr_one(18'd127);
        settle();
        chk("R9 almost_empty at 128", 32'(almost_empty), 0);
        chk("R8 half_full at 128", 32'(half_full), 0);
        chk("R9 almost_full at 128", 32'(almost_full), 0);
        wr_one(18'd128);
        settle();
        chk("R8 half_full at 129", 32'(half_full), 1);
        chk("R9 almost_full at 129", 32'(almost_full), 1);
        chk("R7 std not full", 32'(wr_flag_n), 1);
        wr_burst(DEPTH - 129, 129);
        settle();
        chk("R7 std full", 32'(wr_flag_n), 0);
        wr_one(18'h3FFFF);
        settle();
        for (int i = 0; i < DEPTH; i++) begin
            rd_one();
            chk("R10 drain order after overfill", 32'(rdata), 32'(i));
        end
        settle();
        chk("R3 empty after drain", 32'(rd_flag_n), 0);
        rd_one();
        chk("R10 read when empty holds", 32'(rdata), 32'(DEPTH - 1));
        wr_one(18'h00155);
        wr_one(18'h00156);
        settle();
        rd_one();
        chk("R10 pointer unmoved", 32'(rdata), 32'h155);

        // async reset with data in flight (R12)
        @(negedge rclk);
        #1 mrst_n = 1'b0;
        #1;
        chk("R12 async rdata", 32'(rdata), 0);
        chk("R12 async empty", 32'(rd_flag_n), 0);
        chk("R12 async almost_empty", 32'(almost_empty), 1);

        // ---------------- fall-through mode ----------------
        do_reset(1'b1);
        chk("R7 ft ready after reset", 32'(wr_flag_n), 0);
        chk("R6 ft mode latched", 32'(rd_flag_n), 1);
        @(negedge wclk);
        wdata = 18'h1ABCD;
        wr_en_n = 1'b0;
        @(posedge wclk);
        fork
            begin #1 wr_en_n = 1'b1; end
            begin
                repeat (2) @(posedge rclk);
                #1 chk("R4 not yet after two edges", 32'(rd_flag_n), 1);
                @(posedge rclk);
                #1 chk("R4 ready on third edge", 32'(rd_flag_n), 0);
                chk("R4 word fell through", 32'(rdata), 32'h1ABCD);
            end
        join
        wr_one(18'h00B0B);
        wr_one(18'h00C0C);
        settle();
        chk("R5 head held without read", 32'(rdata), 32'h1ABCD);
        rd_one();
        chk("R5 second word", 32'(rdata), 32'hB0B);
        rd_one();
        chk("R5 third word", 32'(rdata), 32'hC0C);
        chk("R5 still ready", 32'(rd_flag_n), 0);
        rd_one();
        chk("R5 drained not ready", 32'(rd_flag_n), 1);

        // capacity with ready-gated writes (R7 R1)
        acc = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge wclk);
            wdata = DW'(acc);
            wr_en_n = 1'b0;
            if (!wr_flag_n) acc++;
        end
        @(negedge wclk);
        wr_en_n = 1'b1;
        settle();
        chk("R7 ft capacity", 32'(acc), 32'(DEPTH + 1));
        chk("R7 ft not ready when full", 32'(wr_flag_n), 1);
        for (int i = 0; i <= DEPTH; i++) begin
            chk("R1 ft order", 32'(rdata), 32'(i));
            rd_one();
        end
        chk("R5 ft empty after drain", 32'(rd_flag_n), 1);

        summary();
    end
endmodule